// File: doc/BRIEF.md
# Comparator Output Majority Filter

This block cleans up the single-bit decision of an analog comparator before logic acts on it. Near the switching point a comparator chatters, so the raw bit is sampled on a divided-down strobe and passed through a majority vote over the last three or five samples. A length of one sample gives a plain sampled copy. The vote removes isolated glitches at the cost of a fixed, known latency.

Two operating styles exist. In continuous mode the block keeps sampling and updates its filtered result on every sample period once the window is full. In single-shot mode a start pulse launches one comparison. That comparison collects exactly one window of samples, then raises a one-cycle done pulse and holds the result until the next start. Each instance has its own configuration inputs, so several comparators can run with different lengths.

Top module: `cmp_vote_filter`

## Requirements
- R1: While rst_n is low at a clock edge, filt_out, valid and done become 0, and the sample history and prescaler phase are cleared.
- R2: With presc_sel = k, a sample is taken once every 2^k clock cycles. After a clear or an accepted start the phase counter restarts, so the first sample lands on the 2^k-th edge that follows.
- R3: flen_sel encodes the window length: 0 means a single sample (no filtering), 1 means 3 samples, 2 means 5 samples, and 3 behaves like 0.
- R4: When a result is produced, filt_out is 1 exactly when at least N/2+1 of the newest N samples (2 of 3, 3 of 5) are 1, the current sample included.
- R5: In continuous mode (single_mode = 0), valid rises together with the result of the N-th sample after a clear. From then on, filt_out is refreshed on every later sample edge.
- R6: With a window of one sample, filt_out takes the sampled raw_in value one cycle after the sample edge, and valid is 1 after the first sample.
- R7: In single-shot mode, an accepted start clears the history. The N-th sample after it sets filt_out and valid, and done is high for exactly that one following cycle.
- R8: A start while a single-shot comparison is in progress, or any start in continuous mode, has no effect.
- R9: After a single-shot completes, filt_out and valid hold regardless of raw_in until the next accepted start, which drops valid to 0.
- R10: A change of enable, flen_sel or single_mode seen at a clock edge clears the history, filt_out, valid, any comparison in progress and the prescaler phase.
- R11: While enable is 0, no samples are taken and valid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the filter when 1 |
| raw_in | input | 1 | Raw comparator decision, already synchronous to clk |
| flen_sel | input | 2 | Window length select |
| presc_sel | input | 3 | Sample rate exponent k, divide by 2^k |
| single_mode | input | 1 | 0 selects continuous mode, 1 selects single-shot mode |
| start | input | 1 | Launches a single-shot comparison |
| filt_out | output | 1 | Filtered comparator result |
| valid | output | 1 | filt_out holds a complete-window result |
| done | output | 1 | One-cycle pulse at the end of a single-shot comparison |

## Verification
The assertions assume that raw_in and all configuration inputs are already synchronous to clk, and that presc_sel may change without a clear, so the strobe-spacing check allows for a changed select. The stimulus drives every input just after the falling edge. It holds each random configuration for a segment of cycles and switches to a new one at segment boundaries, which exercises the clear path. raw_in is made to persist with occasional flips, so the majority vote sees both long runs and isolated glitches.

// File: rtl/cvf_pkg.sv
// Shared definitions for the comparator vote filter.
// Assumes at most five samples per window.
package cvf_pkg;
    localparam int MAX_TAPS = 5;

    typedef enum logic [1:0] {
        FLEN_OFF  = 2'd0,
        FLEN_MAJ3 = 2'd1,
        FLEN_MAJ5 = 2'd2,
        FLEN_RSVD = 2'd3
    } flen_e;

    // Window length for a length select; the reserved code acts as no filtering.
    function automatic logic [2:0] taps_of(input logic [1:0] sel);
        case (flen_e'(sel))
            FLEN_MAJ3: taps_of = 3'd3;
            FLEN_MAJ5: taps_of = 3'd5;
            default:   taps_of = 3'd1;
        endcase
    endfunction
endpackage

// File: rtl/cvf_prescaler.sv
// Sample strobe generator: one-cycle strobe every 2^sel cycles while run is high.
// Assumes restart is asserted whenever the sample phase must begin anew.
module cvf_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Phase counter: cleared on reset or restart, advances while running.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe when the low sel bits of the phase are all ones.
    always_comb begin
        mask   = ~({CNT_W{1'b1}} << sel);
        strobe = run && ((cnt & mask) == mask);
    end

    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && sel != '0 && !restart) |=> (!strobe || sel != $past(sel))); // R2
endmodule

// File: rtl/cvf_history.sv
// Sample history and majority vote over the newest taps samples.
// The vote includes the sample being offered this cycle; assumes DEPTH >= 3.
module cvf_history #(
    parameter int DEPTH = 5,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          shift,
    input  logic          bit_in,
    input  logic [CW-1:0] taps,
    output logic          vote
);
    logic [DEPTH-2:0] hist;
    logic [DEPTH-1:0] window;
    logic [CW-1:0]    ones;
    logic [CW-1:0]    thresh;

    // Shift register of past samples, newest in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hist <= '0;
        end else if (shift) begin
            hist <= {hist[DEPTH-3:0], bit_in};
        end
    end

    // Count ones in the active part of the window and compare with the majority.
    always_comb begin
        window = {hist, bit_in};
        ones   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < taps) begin
                ones = ones + CW'(window[i]);
            end
        end
        thresh = (taps >> 1) + 1'b1;
        vote   = (ones >= thresh);
    end
endmodule

// File: rtl/cvf_sequencer.sv
// Mode control: detects configuration changes, accepts single-shot starts,
// counts samples and owns the filt_out, valid and done registers.
// Assumes all inputs are synchronous to clk.
module cvf_sequencer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          single_mode,
    input  logic [1:0]    flen_sel,
    input  logic          start,
    input  logic          raw_in,
    input  logic          strobe,
    input  logic          vote,
    input  logic [CW-1:0] taps,
    output logic          restart,
    output logic          take,
    output logic          filt_out,
    output logic          valid,
    output logic          done
);
    logic          en_q, mode_q;
    logic [1:0]    flen_q;
    logic          clr, start_acc, gate, busy;
    logic [CW-1:0] nsamp, nsamp_inc;

    // Remember the configuration seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            flen_q <= '0;
        end else begin
            en_q   <= enable;
            mode_q <= single_mode;
            flen_q <= flen_sel;
        end
    end

    // Decode clear, start acceptance and sample-taking conditions.
    always_comb begin
        clr       = (enable != en_q) || (single_mode != mode_q) || (flen_sel != flen_q);
        start_acc = enable && single_mode && start && !busy && !clr;
        gate      = single_mode ? busy : 1'b1;
        take      = strobe && enable && gate && !clr && !start_acc;
        restart   = clr || start_acc;
        nsamp_inc = (nsamp >= taps) ? taps : nsamp + 1'b1;
    end

    // Sample count, busy flag and the result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsamp    <= '0;
            busy     <= 1'b0;
            filt_out <= 1'b0;
            valid    <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                nsamp    <= '0;
                busy     <= 1'b0;
                filt_out <= 1'b0;
                valid    <= 1'b0;
            end else if (start_acc) begin
                nsamp <= '0;
                busy  <= 1'b1;
                valid <= 1'b0;
            end else if (take) begin
                nsamp <= nsamp_inc;
                if (nsamp_inc == taps) begin
                    filt_out <= vote;
                    valid    <= 1'b1;
                    if (single_mode) begin
                        done <= 1'b1;
                        busy <= 1'b0;
                    end
                end
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_ONLY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_q && valid)); // R7
    AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!valid && !done && !filt_out)); // R10
    AST_VALID_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(take)); // R5
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> $stable(filt_out)); // R9
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take && !clr) |=> busy); // R8
    AST_OFF_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !valid); // R11
    AST_SINGLE_TAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && taps == CW'(1)) |=> (valid && filt_out == $past(raw_in))); // R6
endmodule

// File: rtl/cmp_vote_filter.sv
// Comparator output majority filter, top level.
// Connects the sample strobe, the history/vote and the mode sequencer.
// Assumes raw_in and all configuration inputs are synchronous to clk.
module cmp_vote_filter #(
    parameter int SEL_W = 3,
    parameter int TAPS  = cvf_pkg::MAX_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             raw_in,
    input  logic [1:0]       flen_sel,
    input  logic [SEL_W-1:0] presc_sel,
    input  logic             single_mode,
    input  logic             start,
    output logic             filt_out,
    output logic             valid,
    output logic             done
);
    localparam int CW = 3;

    logic          strobe, restart, take, vote;
    logic [CW-1:0] taps;

    // Window length from the length select.
    always_comb taps = cvf_pkg::taps_of(flen_sel);

    cvf_prescaler #(.SEL_W(SEL_W)) i_presc (
        .clk(clk), .rst_n(rst_n), .run(enable), .restart(restart),
        .sel(presc_sel), .strobe(strobe)
    );

    cvf_history #(.DEPTH(TAPS), .CW(CW)) i_hist (
        .clk(clk), .rst_n(rst_n), .flush(restart), .shift(take),
        .bit_in(raw_in), .taps(taps), .vote(vote)
    );

    cvf_sequencer #(.CW(CW)) i_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .single_mode(single_mode),
        .flen_sel(flen_sel), .start(start), .raw_in(raw_in), .strobe(strobe),
        .vote(vote), .taps(taps), .restart(restart), .take(take),
        .filt_out(filt_out), .valid(valid), .done(done)
    );
endmodule

// File: tb/test_cmp_vote_filter.sv
// Self-checking bench: behavioural model from the requirements, directed
// corner cases and seeded random segments.
module test_cmp_vote_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, raw = 1'b0, md = 1'b0, st = 1'b0;
    logic [1:0] fl = 2'd0;
    logic [2:0] ps = 3'd0;
    logic filt_out, valid, done;
    int n_cmp = 0, n_bad = 0;

    always #4 clk = ~clk;

    cmp_vote_filter i_cmp_vote_filter (
        .clk(clk), .rst_n(rst_n), .enable(en), .raw_in(raw), .flen_sel(fl),
        .presc_sel(ps), .single_mode(md), .start(st),
        .filt_out(filt_out), .valid(valid), .done(done)
    );

    // Behavioural model state
    int m_cnt, m_ns;
    logic m_enq, m_mdq, m_busy, m_out, m_val, m_done;
    logic [1:0] m_flq;
    logic [3:0] m_h;

    function automatic int win_len(input logic [1:0] f);
        if (f == 2'd1) return 3;
        if (f == 2'd2) return 5;
        return 1;
    endfunction

    task automatic model_edge();
        int n, d, ones;
        logic clr, stb;
        logic [4:0] win;
        n = win_len(fl);
        d = 1 << ps;
        if (!rst_n) begin
            m_cnt = 0; m_ns = 0; m_enq = 0; m_mdq = 0; m_flq = 0; m_h = 0;
            m_busy = 0; m_out = 0; m_val = 0; m_done = 0;
            return;
        end
        clr = (en !== m_enq) || (fl !== m_flq) || (md !== m_mdq);
        m_enq = en; m_flq = fl; m_mdq = md;
        m_done = 0;
        if (clr) begin
            m_cnt = 0; m_h = 0; m_ns = 0; m_busy = 0; m_out = 0; m_val = 0;
        end else if (en) begin
            stb = ((m_cnt % d) == d - 1);
            if (md && st && !m_busy) begin
                m_busy = 1; m_ns = 0; m_h = 0; m_val = 0; m_cnt = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 128;
                if (stb && (!md || m_busy)) begin
                    win = {m_h, raw};
                    m_h = {m_h[2:0], raw};
                    if (m_ns < n) m_ns++;
                    if (m_ns == n) begin
                        ones = 0;
                        for (int i = 0; i < n; i++) ones += win[i];
                        m_out = (ones >= n / 2 + 1);
                        m_val = 1;
                        if (md) begin m_done = 1; m_busy = 0; end
                    end
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0b exp %0b", tag, got, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R4 filt_out vs model", filt_out, m_out);
        check("R5 valid vs model", valid, m_val);
        check("R7 done vs model", done, m_done);
    endtask

    task automatic reconfig(input logic e, input logic [1:0] f, input logic [2:0] p, input logic m);
        en = 1'b0; step();
        en = e; fl = f; ps = p; md = m; step();
    endtask

    task automatic wait_valid(input string tag, input int expect_steps);
        int k;
        k = 0;
        while (valid !== 1'b1 && k < 300) begin step(); k++; end
        n_cmp++;
        if (k != expect_steps) begin
            n_bad++;
            $display("FAIL %s got %0d exp %0d", tag, k, expect_steps);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog got hang exp finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        en = 1'b1; raw = 1'b1; fl = 2'd2;
        repeat (3) step();
        check("R1 filt_out after reset", filt_out, 1'b0);
        check("R1 valid after reset", valid, 1'b0);
        check("R1 done after reset", done, 1'b0);
        rst_n = 1'b1;

        // R2: divide by 4, one-sample window: first result on 4th edge
        reconfig(1'b1, 2'd0, 3'd2, 1'b0);
        wait_valid("R2 cycles to first sample at divide 4", 4);
        // R5: three-sample window at full rate
        reconfig(1'b1, 2'd1, 3'd0, 1'b0);
        wait_valid("R5 cycles to first valid with 3 samples", 3);
        // R6: one-sample window follows input
        reconfig(1'b1, 2'd0, 3'd0, 1'b0);
        raw = 1'b1;
        wait_valid("R6 cycles to first valid without filter", 1);
        check("R6 output follows sample", filt_out, 1'b1);
        raw = 1'b0; step();
        check("R6 output follows next sample", filt_out, 1'b0);
        // R3: reserved code acts as no filtering
        reconfig(1'b1, 2'd3, 3'd0, 1'b0);
        wait_valid("R3 reserved length acts as one sample", 1);

        // R4: five-sample vote, pattern 1,1,0,1,0 then 0
        reconfig(1'b1, 2'd2, 3'd0, 1'b0);
        foreach (raw_pat[i]) begin raw = raw_pat[i]; step(); end
        check("R4 valid after five samples", valid, 1'b1);
        check("R4 three of five ones gives 1", filt_out, 1'b1);
        raw = 1'b0; step();
        check("R4 two of five ones gives 0", filt_out, 1'b0);
        // R10: length change clears
        fl = 2'd1; step();
        check("R10 valid cleared by length change", valid, 1'b0);

        // R7/R8/R9: single-shot, five samples, divide 2
        reconfig(1'b1, 2'd2, 3'd1, 1'b1);
        raw = 1'b1; step();
        st = 1'b1; step(); st = 1'b0;
        for (int c = 1; c <= 11; c++) begin
            if (c == 3) st = 1'b1;
            step();
            st = 1'b0;
            if (c < 10) check("R8 no early done despite second start", done, 1'b0);
            if (c == 10) begin
                check("R7 done after fifth sample", done, 1'b1);
                check("R7 result set", filt_out, 1'b1);
            end
            if (c == 11) check("R7 done lasts one cycle", done, 1'b0);
        end
        raw = 1'b0;
        repeat (12) step();
        check("R9 result held", filt_out, 1'b1);
        check("R9 valid held", valid, 1'b1);
        st = 1'b1; step(); st = 1'b0;
        check("R9 start drops valid", valid, 1'b0);
        // R8: start ignored in continuous mode
        reconfig(1'b1, 2'd0, 3'd0, 1'b0);
        raw = 1'b1; step();
        st = 1'b1; step(); st = 1'b0;
        check("R8 start has no effect in continuous", valid, 1'b1);

        // R11: disabled, no sampling
        en = 1'b0;
        for (int c = 0; c < 20; c++) begin
            raw = 1'(($urandom() & 1));
            step();
            check("R11 valid stays low while disabled", valid, 1'b0);
        end

        // Random segments
        for (int s = 0; s < 300; s++) begin
            en = (($urandom() % 8) != 0);
            fl = 2'($urandom() % 4);
            ps = 3'($urandom() % 3);
            md = 1'($urandom() % 2);
            for (int c = 0; c < 40; c++) begin
                if (($urandom() % 4) == 0) raw = ~raw;
                st = (($urandom() % 8) == 0);
                step();
            end
            st = 1'b0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic raw_pat [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
endmodule